// File: doc/BRIEF.md
# Per-CPU Interrupt Delivery Interface

This block sits between an interrupt distributor and one processor. The distributor offers a single candidate on every cycle: its ID, its priority and, for software-generated interrupts, the number of the CPU that raised it. The block decides whether that candidate may interrupt the processor. The candidate must beat a programmable priority floor, and it must preempt whatever the processor is already servicing. When both hold, the block drives a level IRQ output.

Software works through a small register window. Reading the acknowledge word claims the candidate. This tells the distributor to retire the pending state, through a one-cycle `ack_take` pulse. The block also records the candidate's ID and priority on an internal stack of active interrupts. Writing the end-of-interrupt word with the ID of the newest active interrupt pops that entry. This restores the previous running priority and sends an `eoi_done` pulse so the distributor can clear its active bit.

Preemption compares only the group part of each priority. A 3-bit split setting decides how many low bits count as subpriority, so interrupts that differ only in subpriority never nest.

Top module: `irq_cpu_iface`

## Requirements
- R1: The register window uses these byte offsets: 0x00 control (bit 0 is the delivery enable), 0x04 priority floor (bits 7:0), 0x08 group split (bits 2:0), 0x0C acknowledge (read), 0x10 end of interrupt (write), 0x14 running priority (read) and 0x18 highest pending (read). Control, floor and split read back what was written. All three reset to 0.
- R2: While control bit 0 is 0, `irq_out` stays low and an acknowledge read returns 1023.
- R3: A candidate is signalable when all of these hold: it is valid, its priority is numerically below the floor, the stack is not full, and either no interrupt is active or its group priority is numerically below the group part of the running priority. `irq_out` is the registered signalable state and follows it one cycle later.
- R4: The group part is the priority ANDed with a mask chosen by the split value. Values 0 through 7 give masks 0xFE, 0xFC, 0xF8, 0xF0, 0xE0, 0xC0, 0x80 and 0x00.
- R5: An acknowledge read of a signalable candidate returns the ID in bits 9:0. When the ID is below 16, the source CPU is also returned in bits 11:10; otherwise those bits are 0. The read pushes the candidate onto the active stack and pulses `ack_take` with `ack_id` in that same cycle.
- R6: An acknowledge read when no candidate is signalable returns 1023, leaves the stack and running priority unchanged, and gives no `ack_take`.
- R7: An end-of-interrupt write whose bits 9:0 equal the ID on top of the stack pops it and pulses `eoi_done` with `eoi_id`. Any other ID, or a write to an empty stack, is ignored.
- R8: Running priority reads as the priority on top of the stack, or 0xFF when the stack is empty.
- R9: Highest pending reads as the candidate ID, with source bits as in R5, when a candidate is valid, and as 1023 otherwise. It is not filtered by the floor or by preemption.
- R10: The stack holds `STACK_DEPTH` entries (at least 8). When it is full, nothing is signalable and an acknowledge read returns 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, 0 is most urgent |
| cand_src | input | 2 | Requesting CPU for software-generated IDs |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_take | output | 1 | Candidate claimed this cycle |
| ack_id | output | 10 | ID claimed |
| eoi_done | output | 1 | Active interrupt retired this cycle |
| eoi_id | output | 10 | ID retired |

## Verification
The distributor can replace its candidate in the very cycle that software reads the acknowledge word. Both claiming and candidate arbitration then act on the same edge. The bench provokes this by changing the candidate in the same cycle as the acknowledge read. It judges the result correct when the returned word, `ack_id` and the new running priority all belong to the newly presented candidate. The bench also checks that the old candidate leaves no trace.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
   localparam int ID_W   = 10;
   localparam int PRIO_W = 8;
   localparam int SPLIT_W = 3;

   localparam logic [7:0] OFF_CTRL  = 8'h00;
   localparam logic [7:0] OFF_FLOOR = 8'h04;
   localparam logic [7:0] OFF_SPLIT = 8'h08;
   localparam logic [7:0] OFF_ACK   = 8'h0C;
   localparam logic [7:0] OFF_EOI   = 8'h10;
   localparam logic [7:0] OFF_RUN   = 8'h14;
   localparam logic [7:0] OFF_HPEND = 8'h18;

   localparam logic [ID_W-1:0]   NO_IRQ_ID = 10'd1023;
   localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;

   typedef struct packed {
      logic [ID_W-1:0]   id;
      logic [PRIO_W-1:0] prio;
   } act_ent_t;
endpackage

// File: rtl/cpuif_group_mask.sv
module cpuif_group_mask
   import cpuif_pkg::*;
(
   input  logic [SPLIT_W-1:0] split,
   output logic [PRIO_W-1:0]  gmask
);
   // bit b of the priority belongs to the group part when b > split
   for (genvar b = 0; b < PRIO_W; b++) begin : g_bit
      assign gmask[b] = (b > int'(split));
   end
endmodule

// File: rtl/cpuif_preempt.sv
module cpuif_preempt
   import cpuif_pkg::*;
(
   input  logic              en,
   input  logic              cand_valid,
   input  logic [PRIO_W-1:0] cand_prio,
   input  logic [PRIO_W-1:0] floor_prio,
   input  logic [PRIO_W-1:0] run_prio,
   input  logic [PRIO_W-1:0] gmask,
   input  logic              stk_empty,
   input  logic              stk_full,
   output logic              fire
);
   logic below_floor, beats_running;

   always_comb begin
      below_floor   = cand_prio < floor_prio;
      beats_running = stk_empty || ((cand_prio & gmask) < (run_prio & gmask));
      fire          = en && cand_valid && !stk_full && below_floor && beats_running;
   end
endmodule

// File: rtl/cpuif_act_stack.sv
module cpuif_act_stack
   import cpuif_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  act_ent_t                   push_ent,
   input  logic                       pop,
   output act_ent_t                   top_ent,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       empty,
   output logic                       full
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   act_ent_t           slots [DEPTH];
   logic [CNT_W-1:0]   cnt_q;
   logic [IDX_W-1:0]   top_idx, wr_idx;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign count   = cnt_q;
   assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
   assign wr_idx  = IDX_W'(cnt_q);
   assign top_ent = empty ? act_ent_t'{id: NO_IRQ_ID, prio: IDLE_PRIO} : slots[top_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
      end else if (push && !full) begin
         slots[wr_idx] <= push_ent;
         cnt_q         <= cnt_q + CNT_W'(1);
      end else if (pop && !empty) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/irq_cpu_iface.sv
module irq_cpu_iface
   import cpuif_pkg::*;
#(
   parameter int STACK_DEPTH = 8,
   parameter int ADDR_W      = 5,
   parameter int SGI_COUNT   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cand_valid,
   input  logic [9:0]        cand_id,
   input  logic [7:0]        cand_prio,
   input  logic [1:0]        cand_src,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq_out,
   output logic              ack_take,
   output logic [9:0]        ack_id,
   output logic              eoi_done,
   output logic [9:0]        eoi_id
);
   localparam int CNT_W = $clog2(STACK_DEPTH + 1);

   if (STACK_DEPTH < 8) begin : g_bad_depth
      $error("STACK_DEPTH must be at least 8");
   end
   if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
      $error("ADDR_W must lie in 5..8");
   end
   if (SGI_COUNT < 1 || SGI_COUNT > 1023) begin : g_bad_sgi
      $error("SGI_COUNT out of range");
   end

   logic               ctrl_en;
   logic [PRIO_W-1:0]  floor_q;
   logic [SPLIT_W-1:0] split_q;
   logic               irq_q;

   logic [PRIO_W-1:0]  gmask, run_prio;
   act_ent_t           top_ent;
   logic [CNT_W-1:0]   stk_count;
   logic               stk_empty, stk_full, fire;
   logic [1:0]         src_field;
   logic               sel_ctrl, sel_floor, sel_split, sel_ack, sel_eoi, sel_run, sel_hpend;
   logic               unused_wdata;

   assign unused_wdata = ^reg_wdata[31:ID_W];

   assign sel_ctrl  = reg_addr == ADDR_W'(OFF_CTRL);
   assign sel_floor = reg_addr == ADDR_W'(OFF_FLOOR);
   assign sel_split = reg_addr == ADDR_W'(OFF_SPLIT);
   assign sel_ack   = reg_addr == ADDR_W'(OFF_ACK);
   assign sel_eoi   = reg_addr == ADDR_W'(OFF_EOI);
   assign sel_run   = reg_addr == ADDR_W'(OFF_RUN);
   assign sel_hpend = reg_addr == ADDR_W'(OFF_HPEND);

   cpuif_group_mask u_mask (
      .split (split_q),
      .gmask (gmask)
   );

   cpuif_preempt u_pre (
      .en         (ctrl_en),
      .cand_valid (cand_valid),
      .cand_prio  (cand_prio),
      .floor_prio (floor_q),
      .run_prio   (run_prio),
      .gmask      (gmask),
      .stk_empty  (stk_empty),
      .stk_full   (stk_full),
      .fire       (fire)
   );

   assign ack_take = reg_rd && !reg_wr && sel_ack && fire;
   assign ack_id   = cand_id;
   assign eoi_done = reg_wr && sel_eoi && !stk_empty && (reg_wdata[ID_W-1:0] == top_ent.id);
   assign eoi_id   = top_ent.id;

   cpuif_act_stack #(.DEPTH(STACK_DEPTH)) u_stk (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (ack_take),
      .push_ent (act_ent_t'{id: cand_id, prio: cand_prio}),
      .pop      (eoi_done),
      .top_ent  (top_ent),
      .count    (stk_count),
      .empty    (stk_empty),
      .full     (stk_full)
   );

   assign run_prio  = top_ent.prio;
   assign src_field = (int'(cand_id) < SGI_COUNT) ? cand_src : 2'b00;

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         if (sel_ctrl)       reg_rdata[0]          = ctrl_en;
         else if (sel_floor) reg_rdata[PRIO_W-1:0] = floor_q;
         else if (sel_split) reg_rdata[SPLIT_W-1:0] = split_q;
         else if (sel_ack)   reg_rdata[11:0] = fire ? {src_field, cand_id} : {2'b00, NO_IRQ_ID};
         else if (sel_run)   reg_rdata[PRIO_W-1:0] = run_prio;
         else if (sel_hpend) reg_rdata[11:0] = cand_valid ? {src_field, cand_id} : {2'b00, NO_IRQ_ID};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en <= 1'b0;
         floor_q <= '0;
         split_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= fire;
         if (reg_wr && sel_ctrl)  ctrl_en <= reg_wdata[0];
         if (reg_wr && sel_floor) floor_q <= reg_wdata[PRIO_W-1:0];
         if (reg_wr && sel_split) split_q <= reg_wdata[SPLIT_W-1:0];
      end
   end

   assign irq_out = irq_q;
endmodule

// File: rtl/irq_cpu_iface_chk.sv
module irq_cpu_iface_chk #(
   parameter int DEPTH = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       ctrl_en,
   input logic                       irq_out,
   input logic                       ack_take,
   input logic                       eoi_done,
   input logic [$clog2(DEPTH+1)-1:0] depth,
   input logic [7:0]                 run_prio
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   p_irq_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(ctrl_en));

   p_push_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_take |=> depth == CNT_W'($past(depth) + 1'b1));

   p_pop_on_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_done |=> depth == CNT_W'($past(depth) - 1'b1));

   p_eoi_needs_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_done |-> depth != '0);

   p_idle_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
      depth == '0 |-> run_prio == 8'hFF);

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= CNT_W'(DEPTH));

   p_full_blocks_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      depth == CNT_W'(DEPTH) |-> !ack_take);

   p_single_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_take && eoi_done));
endmodule

bind irq_cpu_iface irq_cpu_iface_chk #(.DEPTH(STACK_DEPTH)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl_en  (ctrl_en),
   .irq_out  (irq_out),
   .ack_take (ack_take),
   .eoi_done (eoi_done),
   .depth    (stk_count),
   .run_prio (run_prio)
);

// File: tb/irq_cpu_iface_tb_top.sv
`timescale 1ns/1ps
module irq_cpu_iface_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cand_valid = 1'b0;
   logic [9:0]  cand_id = '0;
   logic [7:0]  cand_prio = '0;
   logic [1:0]  cand_src = '0;
   logic        reg_rd = 1'b0, reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_out, ack_take, eoi_done;
   logic [9:0]  ack_id, eoi_id;

   int n_checks = 0, n_fail = 0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   irq_cpu_iface dut_i (
      .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
      .cand_prio(cand_prio), .cand_src(cand_src), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out), .ack_take(ack_take), .ack_id(ack_id),
      .eoi_done(eoi_done), .eoi_id(eoi_id)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // all bus tasks start and end just after a falling edge
   task automatic bus_rd(input logic [4:0] a, output logic [31:0] d, output logic took, output logic [9:0] tid);
      reg_rd = 1'b1; reg_addr = a;
      #1; d = reg_rdata; took = ack_take; tid = ack_id;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic bus_wr(input logic [4:0] a, input logic [31:0] v, output logic fin, output logic [9:0] fid);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
      #1; fin = eoi_done; fid = eoi_id;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic cfg(input logic [4:0] a, input logic [31:0] v);
      logic f; logic [9:0] i;
      bus_wr(a, v, f, i);
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      logic t; logic [9:0] i;
      bus_rd(a, d, t, i);
   endtask

   task automatic offer(input logic v, input logic [9:0] id, input logic [7:0] p, input logic [1:0] s);
      cand_valid = v; cand_id = id; cand_prio = p; cand_src = s;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      check("R1", "irq after reset", {31'b0, irq_out}, 0);
      rd(5'h00, d); check("R1", "control reset", d, 0);
      rd(5'h04, d); check("R1", "floor reset", d, 0);
      rd(5'h08, d); check("R1", "split reset", d, 0);
      rd(5'h14, d); check("R8", "running idle", d, 32'hFF);
      rd(5'h18, d); check("R9", "hpend none", d, 1023);
      cfg(5'h04, 32'hFFFF_FFA5); rd(5'h04, d); check("R1", "floor readback", d, 32'hA5);
      cfg(5'h08, 32'h0000_000E); rd(5'h08, d); check("R1", "split readback", d, 6);
      cfg(5'h08, 0);
   endtask

   task automatic t_enable_gate;
      logic [31:0] d; logic t; logic [9:0] i;
      cfg(5'h04, 32'hF0);
      offer(1'b1, 10'd40, 8'h40, 2'd3);
      @(negedge clk);
      check("R2", "irq while disabled", {31'b0, irq_out}, 0);
      bus_rd(5'h0C, d, t, i);
      check("R2", "ack while disabled", d, 1023);
      check("R6", "no take while disabled", {31'b0, t}, 0);
      rd(5'h14, d); check("R6", "running untouched", d, 32'hFF);
      cfg(5'h00, 1);
      @(negedge clk);
      check("R3", "irq once enabled", {31'b0, irq_out}, 1);
      rd(5'h00, d); check("R1", "control readback", d, 1);
   endtask

   task automatic t_ack_nest;
      logic [31:0] d; logic t; logic [9:0] i;
      bus_rd(5'h0C, d, t, i);
      check("R5", "ack id>=16 has no source", d, 40);
      check("R5", "take pulse", {21'b0, t, i}, {21'b0, 1'b1, 10'd40});
      offer(1'b0, 0, 0, 0);
      rd(5'h14, d); check("R8", "running after first ack", d, 32'h40);
      // software-generated candidate of more urgent group
      offer(1'b1, 10'd5, 8'h20, 2'd2);
      bus_rd(5'h0C, d, t, i);
      check("R5", "ack with source", d, 32'h805);
      offer(1'b0, 0, 0, 0);
      rd(5'h14, d); check("R8", "running nested", d, 32'h20);
      // same group as running (mask 0xFE) does not preempt
      offer(1'b1, 10'd60, 8'h21, 0);
      @(negedge clk); @(negedge clk);
      check("R4", "same group blocked", {31'b0, irq_out}, 0);
      offer(1'b1, 10'd60, 8'h1F, 0);
      @(negedge clk); @(negedge clk);
      check("R3", "lower group preempts", {31'b0, irq_out}, 1);
      offer(1'b1, 10'd60, 8'h11, 0);
      cfg(5'h08, 4);   // mask 0xE0: 0x00 < 0x20
      @(negedge clk);
      check("R4", "split 4 preempts", {31'b0, irq_out}, 1);
      cfg(5'h08, 5);   // mask 0xC0: 0x00 vs 0x00
      @(negedge clk);
      check("R4", "split 5 blocks", {31'b0, irq_out}, 0);
      cfg(5'h08, 7);   // mask 0x00
      offer(1'b1, 10'd60, 8'h00, 0);
      @(negedge clk); @(negedge clk);
      check("R4", "split 7 never preempts", {31'b0, irq_out}, 0);
      cfg(5'h08, 0);
      offer(1'b0, 0, 0, 0);
   endtask

   task automatic t_eoi;
      logic [31:0] d; logic f; logic [9:0] i;
      bus_wr(5'h10, 32'd40, f, i);
      check("R7", "mismatched eoi ignored", {31'b0, f}, 0);
      rd(5'h14, d); check("R7", "running kept after mismatch", d, 32'h20);
      bus_wr(5'h10, 32'hFFFF_FC05, f, i);
      check("R7", "matching eoi", {21'b0, f, i}, {21'b0, 1'b1, 10'd5});
      rd(5'h14, d); check("R8", "running restored", d, 32'h40);
      bus_wr(5'h10, 32'd40, f, i);
      check("R7", "second eoi", {31'b0, f}, 1);
      rd(5'h14, d); check("R8", "running idle again", d, 32'hFF);
      bus_wr(5'h10, 32'd40, f, i);
      check("R7", "eoi on empty ignored", {31'b0, f}, 0);
   endtask

   task automatic t_floor_edge;
      logic [31:0] d;
      cfg(5'h04, 32'h30);
      offer(1'b1, 10'd70, 8'h30, 0);
      @(negedge clk); @(negedge clk);
      check("R3", "priority equal to floor blocked", {31'b0, irq_out}, 0);
      rd(5'h18, d); check("R9", "hpend ignores floor", d, 70);
      offer(1'b1, 10'd70, 8'h2F, 0);
      @(negedge clk); @(negedge clk);
      check("R3", "priority below floor", {31'b0, irq_out}, 1);
      offer(1'b0, 0, 0, 0);
      rd(5'h18, d); check("R9", "hpend no candidate", d, 1023);
   endtask

   task automatic t_full;
      logic [31:0] d; logic t, f; logic [9:0] i;
      int acks = 0;
      cfg(5'h04, 32'hFF);
      for (int k = 0; k < 8; k++) begin
         offer(1'b1, 10'(100 + k), 8'(8'h80 - 8'h10 * k), 0);
         bus_rd(5'h0C, d, t, i);
         if (t) acks++;
      end
      check("R10", "eight nested acks", acks, 8);
      offer(1'b1, 10'd200, 8'h00, 0);
      @(negedge clk); @(negedge clk);
      check("R10", "full stack blocks irq", {31'b0, irq_out}, 0);
      bus_rd(5'h0C, d, t, i);
      check("R10", "full stack ack", d, 1023);
      rd(5'h14, d); check("R10", "running at full", d, 32'h10);
      offer(1'b0, 0, 0, 0);
      for (int k = 7; k >= 0; k--) bus_wr(5'h10, 32'(100 + k), f, i);
      rd(5'h14, d); check("R7", "stack unwound", d, 32'hFF);
   endtask

   task automatic t_swap_on_ack;
      logic [31:0] d; logic t; logic [9:0] i;
      offer(1'b1, 10'd80, 8'h50, 0);
      @(negedge clk);
      offer(1'b1, 10'd3, 8'h60, 2'd1);   // candidate replaced in the ack cycle
      bus_rd(5'h0C, d, t, i);
      check("R5", "swap ack word", d, 32'h403);
      check("R5", "swap ack id", {22'b0, i}, 3);
      offer(1'b0, 0, 0, 0);
      rd(5'h14, d); check("R8", "swap running", d, 32'h60);
      cfg(5'h10, 3);
      rd(5'h14, d); check("R7", "swap retired", d, 32'hFF);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable_gate();
      t_ack_nest();
      t_eoi();
      t_floor_edge();
      t_full();
      t_swap_on_ack();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule